// File: doc/BRIEF.md
# Generation-Bit Egress Descriptor Ring Consumer

This block drains a circular ring of two-word egress descriptors that a producer writes into local memory. The block does not exchange head and tail pointers with the producer. Instead, it compares bit 0 of each slot's first word (the generation bit) with an expected phase that it keeps internally. The producer inverts the generation value it writes each time its tail wraps. The consumer inverts its expected phase each time its head index wraps. A slot is therefore new exactly when the two values agree.

For each accepted descriptor, the block decodes the control fields and presents one transfer command downstream under a valid/ready handshake. The command carries the byte count, whether bytes actually move, whether a buffer return applies, the checksum request, the end-of-packet mark and the buffer word. Descriptors with nonzero reserved bits are dropped and latch a sticky error. The block keeps, in order, one notify flag per packet it has issued. When the egress path reports a finished packet on `done_i`, the block pulses `notif_o` if any descriptor of that packet asked for a notification.

Top module: `desc_ring_consumer`

## Requirements
- R1: After reset the expected phase is 1 and the head index is 0. `cmd_valid_o`, `notif_o` and `rsv_err_o` are low, so a ring of all-zero slots yields no command.
- R2: A slot is consumed only when its word-0 bit 0 equals the expected phase. While the head slot does not match, the block re-reads that same slot, issues no command and raises no error.
- R3: The command fields come from word 0 as follows: bit 8 drives `cmd_csum_o`, bit 9 is the no-send flag, bit 10 drives `cmd_note_o`, bit 11 drives `cmd_last_o`, and bits 29:16 drive `cmd_len_o`.
- R4: `cmd_send_o` is 1 only when the no-send flag is 0 and the byte count is nonzero. `cmd_ret_o` is 1 whenever the byte count is nonzero, including when the no-send flag is set.
- R5: When the byte count is nonzero, `cmd_buf_o` equals word 1 (`ring_rd_data_i[127:64]`). When the byte count is zero, `cmd_buf_o` is zero.
- R6: The head index advances by exactly one for each consumed or skipped descriptor. The expected phase inverts when the head moves from slot DEPTH-1 to slot 0.
- R7: A descriptor with any nonzero bit in word-0 bits 7:1, 15:12 or 31:30 produces no command and sets `rsv_err_o`. `rsv_err_o` stays set until reset, and the ring moves on to the next slot.
- R8: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command stays valid and every command field holds its value.
- R9: A packet's notify flag is the OR of bit 10 over all of its descriptors. Each `done_i` pulse completes the oldest issued packet, and `notif_o` pulses in the next cycle exactly when that packet's flag is set. A `done_i` pulse with no packet outstanding has no effect.
- R10: At most NQ packets are outstanding. A command with the end-of-packet bit set is held back while NQ packets await completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_rd_en_o | output | 1 | Ring read request |
| ring_rd_idx_o | output | $clog2(DEPTH) | Slot index to read |
| ring_rd_data_i | input | 128 | Slot contents one cycle after the request; word 1 is in the upper half |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Downstream accepts the command |
| cmd_len_o | output | 14 | Byte count |
| cmd_send_o | output | 1 | Bytes are transmitted |
| cmd_ret_o | output | 1 | Buffer return applies |
| cmd_csum_o | output | 1 | Checksum requested |
| cmd_last_o | output | 1 | End of packet |
| cmd_note_o | output | 1 | Descriptor notify bit |
| cmd_buf_o | output | 64 | Buffer word, or zero |
| done_i | input | 1 | Oldest issued packet has left the egress path |
| notif_o | output | 1 | Notification pulse |
| rsv_err_o | output | 1 | Sticky reserved-field error |

## Verification
A completion arriving on `done_i` and the handshake of a new end-of-packet command can fall in the same clock edge. In that case the outstanding-packet queue pops its oldest entry and appends a new one at once. The bench provokes this by holding `cmd_ready_i` low until the command is valid, then raising `cmd_ready_i` and `done_i` together. The older packet is given no notify flag and the newer one is given a flag. The following `notif_o` values must then read 0 and then 1, and a final extra `done_i` must leave `notif_o` low.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int WORD_W  = 64;
  localparam int SLOT_W  = 2 * WORD_W;
  localparam int LEN_W   = 14;
  localparam int LEN_LSB = 16;
  localparam int B_GEN   = 0;
  localparam int B_CSUM  = 8;
  localparam int B_NOSND = 9;
  localparam int B_NOTE  = 10;
  localparam int B_LAST  = 11;

  typedef enum logic [1:0] {F_REQ, F_CHK, F_HOLD} fetch_st_e;

  typedef struct packed {
    logic             csum;
    logic             nosend;
    logic             note;
    logic             last;
    logic [LEN_W-1:0] len;
    logic             rsv_bad;
  } ctl_t;
endpackage

// File: rtl/ring_fetch.sv
module ring_fetch
  import dring_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [SLOT_W-1:0] rd_data_i,
  input  logic              take_i,
  output logic              hold_vld_o,
  output logic [WORD_W-1:0] hold_w0_o,
  output logic [WORD_W-1:0] hold_w1_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  fetch_st_e         st_q;
  logic [IDX_W-1:0]  head_q;
  logic              phase_q;
  logic [WORD_W-1:0] w0_q, w1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= F_REQ;
      head_q  <= '0;
      phase_q <= 1'b1;
      w0_q    <= '0;
      w1_q    <= '0;
    end else begin
      unique case (st_q)
        F_REQ: st_q <= F_CHK;
        F_CHK: begin
          if (rd_data_i[B_GEN] == phase_q) begin
            w0_q <= rd_data_i[WORD_W-1:0];
            w1_q <= rd_data_i[SLOT_W-1:WORD_W];
            st_q <= F_HOLD;
          end else begin
            st_q <= F_REQ;  // stale slot: poll again
          end
        end
        F_HOLD: begin
          if (take_i) begin
            head_q <= head_q + 1'b1;
            if (head_q == LAST_IDX) phase_q <= ~phase_q;
            st_q <= F_REQ;
          end
        end
        default: st_q <= F_REQ;
      endcase
    end
  end

  assign rd_en_o    = (st_q == F_REQ);
  assign rd_idx_o   = head_q;
  assign hold_vld_o = (st_q == F_HOLD);
  assign hold_w0_o  = w0_q;
  assign hold_w1_o  = w1_q;

  assert_phase_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> (head_q == '0 && $past(head_q) == LAST_IDX));
  assert_head_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_q != $past(head_q)) |-> (head_q == IDX_W'($past(head_q) + 1'b1)));
  assert_gen_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_vld_o) |-> ($past(rd_data_i[B_GEN]) == phase_q));
endmodule

// File: rtl/desc_decode.sv
module desc_decode
  import dring_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  output ctl_t              ctl_o,
  output logic              send_o,
  output logic              ret_o,
  output logic [WORD_W-1:0] buf_o
);
  logic len_nz;

  always_comb begin
    ctl_o.csum    = w0_i[B_CSUM];
    ctl_o.nosend  = w0_i[B_NOSND];
    ctl_o.note    = w0_i[B_NOTE];
    ctl_o.last    = w0_i[B_LAST];
    ctl_o.len     = w0_i[LEN_LSB +: LEN_W];
    ctl_o.rsv_bad = (|w0_i[7:1]) | (|w0_i[15:12]) | (|w0_i[31:30]);
  end

  assign len_nz = |ctl_o.len;
  assign send_o = len_nz & ~ctl_o.nosend;
  assign ret_o  = len_nz;  // buffer return survives no-send
  assign buf_o  = len_nz ? w1_i : '0;
endmodule

// File: rtl/note_queue.sv
module note_queue #(
  parameter int NQ = 8,
  localparam int CW = $clog2(NQ + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic push_bit_i,
  input  logic done_i,
  output logic full_o,
  output logic notif_o
);
  logic [NQ-1:0] q_q, q_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop, notif_q;

  assign pop = done_i && (cnt_q != '0);

  always_comb begin
    q_d   = q_q;
    cnt_d = cnt_q;
    if (pop) begin
      q_d   = q_q >> 1;
      cnt_d = cnt_q - 1'b1;
    end
    if (push_i) begin
      for (int i = 0; i < NQ; i++)
        if (i == int'(cnt_d)) q_d[i] = push_bit_i;
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '0;
      cnt_q   <= '0;
      notif_q <= 1'b0;
    end else begin
      q_q     <= q_d;
      cnt_q   <= cnt_d;
      notif_q <= pop & q_q[0];
    end
  end

  assign full_o  = (cnt_q == CW'(NQ));
  assign notif_o = notif_q;

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NQ));
  assert_no_push_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o));
  assert_notif_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notif_o |-> $past(done_i));
endmodule

// File: rtl/desc_ring_consumer.sv
module desc_ring_consumer
  import dring_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NQ    = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              ring_rd_en_o,
  output logic [IDX_W-1:0]  ring_rd_idx_o,
  input  logic [127:0]      ring_rd_data_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [13:0]       cmd_len_o,
  output logic              cmd_send_o,
  output logic              cmd_ret_o,
  output logic              cmd_csum_o,
  output logic              cmd_last_o,
  output logic              cmd_note_o,
  output logic [63:0]       cmd_buf_o,
  input  logic              done_i,
  output logic              notif_o,
  output logic              rsv_err_o
);
  logic              hold_vld, take, hs, q_full, skip;
  logic [WORD_W-1:0] w0, w1;
  ctl_t              ctl;
  logic              pkt_note_q, err_q;

  ring_fetch #(.DEPTH(DEPTH)) u_fetch (
    .clk_i, .rst_ni,
    .rd_en_o(ring_rd_en_o), .rd_idx_o(ring_rd_idx_o), .rd_data_i(ring_rd_data_i),
    .take_i(take), .hold_vld_o(hold_vld), .hold_w0_o(w0), .hold_w1_o(w1)
  );

  desc_decode u_dec (
    .w0_i(w0), .w1_i(w1), .ctl_o(ctl),
    .send_o(cmd_send_o), .ret_o(cmd_ret_o), .buf_o(cmd_buf_o)
  );

  assign skip        = hold_vld & ctl.rsv_bad;
  assign cmd_valid_o = hold_vld & ~ctl.rsv_bad & ~(ctl.last & q_full);
  assign hs          = cmd_valid_o & cmd_ready_i;
  assign take        = skip | hs;

  assign cmd_len_o  = ctl.len;
  assign cmd_csum_o = ctl.csum;
  assign cmd_last_o = ctl.last;
  assign cmd_note_o = ctl.note;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_note_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (skip) err_q <= 1'b1;
      if (hs) pkt_note_q <= ctl.last ? 1'b0 : (pkt_note_q | ctl.note);
    end
  end
  assign rsv_err_o = err_q;

  note_queue #(.NQ(NQ)) u_noteq (
    .clk_i, .rst_ni,
    .push_i(hs & ctl.last), .push_bit_i(pkt_note_q | ctl.note),
    .done_i, .full_o(q_full), .notif_o
  );

  assert_cmd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_len_o) && $stable(cmd_buf_o)
                                       && $stable(cmd_last_o)));
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_err_o |=> rsv_err_o);
  assert_err_no_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsv_err_o) |-> !$past(cmd_valid_o));
endmodule

// File: tb/desc_ring_consumer_tb.sv
module desc_ring_consumer_tb;
  localparam int DEPTH = 4;
  localparam int NQ    = 2;
  localparam int IDX_W = $clog2(DEPTH);

  typedef struct packed {
    logic        last, note, nosend, csum;
    logic [13:0] len;
    logic        rsv;
    logic [63:0] w1;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 14'd100,   1'b0, 64'hA000_0000_0000_0001},
    '{1'b1, 1'b1, 1'b0, 1'b0, 14'd64,    1'b0, 64'hA000_0000_0000_0002},
    '{1'b1, 1'b0, 1'b1, 1'b0, 14'd200,   1'b0, 64'hA000_0000_0000_0003},
    '{1'b1, 1'b1, 1'b0, 1'b0, 14'd0,     1'b0, 64'hA000_0000_0000_0004},
    '{1'b1, 1'b0, 1'b0, 1'b1, 14'd16383, 1'b0, 64'hA000_0000_0000_0005},
    '{1'b1, 1'b1, 1'b0, 1'b0, 14'd9,     1'b1, 64'hA000_0000_0000_0006},
    '{1'b0, 1'b1, 1'b1, 1'b0, 14'd1,     1'b0, 64'hA000_0000_0000_0007},
    '{1'b1, 1'b0, 1'b1, 1'b0, 14'd0,     1'b0, 64'hA000_0000_0000_0008}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ring_rd_en_o; logic [IDX_W-1:0] ring_rd_idx_o; logic [127:0] ring_rd_data_i = '0;
  logic cmd_valid_o, cmd_ready_i = 1'b1;
  logic [13:0] cmd_len_o; logic cmd_send_o, cmd_ret_o, cmd_csum_o, cmd_last_o, cmd_note_o;
  logic [63:0] cmd_buf_o; logic done_i = 1'b0, notif_o, rsv_err_o;

  logic [63:0] ring_w0 [DEPTH];
  logic [63:0] ring_w1 [DEPTH];
  int total = 0, fails = 0, hs_cnt = 0, cyc = 0, slot = 0;
  logic phase_tb = 1'b1, acc_note = 1'b0;

  always #2 clk_i = ~clk_i;

  desc_ring_consumer #(.DEPTH(DEPTH), .NQ(NQ)) u_dut (.*);

  always @(posedge clk_i) begin
    if (ring_rd_en_o) ring_rd_data_i <= {ring_w1[ring_rd_idx_o], ring_w0[ring_rd_idx_o]};
    if (rst_ni && cmd_valid_o && cmd_ready_i) hs_cnt <= hs_cnt + 1;
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1; total = total + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_slot(input vec_t v);
    ring_w0[slot] = {32'h0, 2'b00, v.len, 4'h0, v.last, v.note, v.nosend, v.csum,
                     v.rsv ? 7'h10 : 7'h00, phase_tb};
    ring_w1[slot] = v.w1;
    slot = (slot + 1) % DEPTH;
    if (slot == 0) phase_tb = ~phase_tb;
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    while (!cmd_valid_o && n < 60) begin @(negedge clk_i); n++; end
    chk(req, 64'(cmd_valid_o), 64'd1);
  endtask

  task automatic pulse_done(input logic exp_note, input string req);
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
    chk(req, 64'(notif_o), 64'(exp_note));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin ring_w0[i] = '0; ring_w1[i] = '0; end
    slot = 0; phase_tb = 1'b1; acc_note = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    int h0;
    do_reset();
    chk("R1 valid", 64'(cmd_valid_o), 0);
    chk("R1 err", 64'(rsv_err_o), 0);
    chk("R1 notif", 64'(notif_o), 0);
    chk("R1 idx", 64'(ring_rd_idx_o), 0);
    rst_ni = 1'b1;
    repeat (12) @(negedge clk_i);
    chk("R2 stale ring no cmd", 64'(hs_cnt), 0);
    chk("R2 stale no err", 64'(rsv_err_o), 0);

    // table walk: two wraps of a 4-slot ring
    for (int k = 0; k < 8; k++) begin
      h0 = hs_cnt;
      wr_slot(VEC[k]);
      if (VEC[k].rsv) begin
        repeat (8) @(negedge clk_i);
        chk("R7 skipped no cmd", 64'(hs_cnt), 64'(h0));
        chk("R7 err set", 64'(rsv_err_o), 1);
      end else begin
        wait_valid("R2/R6 slot consumed");
        chk("R3 len", 64'(cmd_len_o), 64'(VEC[k].len));
        chk("R3 csum", 64'(cmd_csum_o), 64'(VEC[k].csum));
        chk("R3 last", 64'(cmd_last_o), 64'(VEC[k].last));
        chk("R3 note", 64'(cmd_note_o), 64'(VEC[k].note));
        chk("R4 send", 64'(cmd_send_o), 64'(!VEC[k].nosend && VEC[k].len != 0));
        chk("R4 ret", 64'(cmd_ret_o), 64'(VEC[k].len != 0));
        chk("R5 buf", cmd_buf_o, (VEC[k].len != 0) ? VEC[k].w1 : 64'h0);
        @(negedge clk_i);
        chk("R6 one handshake", 64'(hs_cnt), 64'(h0 + 1));
        acc_note = acc_note | VEC[k].note;
        if (VEC[k].last) begin
          pulse_done(acc_note, "R9 notif per packet");
          acc_note = 1'b0;
        end
      end
    end
    chk("R7 err sticky", 64'(rsv_err_o), 1);

    // backpressure hold
    cmd_ready_i = 1'b0;
    wr_slot('{1'b1, 1'b0, 1'b0, 1'b0, 14'd50, 1'b0, 64'hB0});
    wait_valid("R8 valid");
    repeat (4) @(negedge clk_i);
    chk("R8 held valid", 64'(cmd_valid_o), 1);
    chk("R8 held len", 64'(cmd_len_o), 50);
    chk("R8 held buf", cmd_buf_o, 64'hB0);
    cmd_ready_i = 1'b1;
    @(negedge clk_i);
    pulse_done(1'b0, "R9 no-note packet");

    // same-cycle push and pop
    wr_slot('{1'b1, 1'b0, 1'b0, 1'b0, 14'd10, 1'b0, 64'hC1});
    wait_valid("R9 pkt A");
    @(negedge clk_i);
    cmd_ready_i = 1'b0;
    wr_slot('{1'b1, 1'b1, 1'b0, 1'b0, 14'd11, 1'b0, 64'hC2});
    wait_valid("R9 pkt C");
    h0 = hs_cnt;
    cmd_ready_i = 1'b1;
    pulse_done(1'b0, "R9 pop A during push C");
    chk("R9 C accepted", 64'(hs_cnt), 64'(h0 + 1));
    pulse_done(1'b1, "R9 pop C");
    pulse_done(1'b0, "R9 done with empty queue ignored");

    // full queue withholds end-of-packet
    wr_slot('{1'b1, 1'b0, 1'b0, 1'b0, 14'd5, 1'b0, 64'hD1});
    wait_valid("R10 p1"); @(negedge clk_i);
    wr_slot('{1'b1, 1'b0, 1'b0, 1'b0, 14'd6, 1'b0, 64'hD2});
    wait_valid("R10 p2"); @(negedge clk_i);
    h0 = hs_cnt;
    wr_slot('{1'b1, 1'b1, 1'b0, 1'b0, 14'd7, 1'b0, 64'hD3});
    repeat (10) @(negedge clk_i);
    chk("R10 blocked valid", 64'(cmd_valid_o), 0);
    chk("R10 blocked hs", 64'(hs_cnt), 64'(h0));
    pulse_done(1'b0, "R10 pop p1");
    wait_valid("R10 released");
    chk("R10 released len", 64'(cmd_len_o), 7);
    @(negedge clk_i);
    pulse_done(1'b0, "R10 pop p2");
    pulse_done(1'b1, "R10 pop p3");

    do_reset();
    chk("R1 err cleared", 64'(rsv_err_o), 0);
    chk("R1 valid cleared", 64'(cmd_valid_o), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule